// File: doc/BRIEF.md
# Masked Busy and Error Aggregator with Reset Handshake

This block gathers three kinds of status return from up to five downstream modules: busy, reset-request and fatal error. Each return is captured in a register. Each captured bit is then gated by its own enable bit and ORed within its group. The block merges the gated groups with its own busy sources and with busy and fatal-error bits set by software. From these it drives one busy line and one fatal-error line back to the trigger system.

Busy caused by a reset-request is not raised as soon as the request appears. It is raised on the next accept, so the trigger system sees busy in step with the event that could not be served. Busy then stays up while the request persists. When the request goes away, the block sends a one-cycle reset to the front end and only after that drops the error busy. Each valid accept also starts a fixed-length internal busy window. A test busy latch can be set by triggers and cleared by command. In local operation the busy line is held high at all times.

Top module: `busy_err_combiner`

## Requirements
- R1: The return inputs are captured on the clock edge, so a change at the inputs reaches the outputs one cycle later. Bit i of each return vector and of each enable vector belongs to module i. A return bit counts only when its enable bit is 1; with the enable bit at 0 the return has no effect.
- R2: `err_irq` is high exactly when some captured reset-request bit has its enable bit set.
- R3: `ferr_out` is the OR of the enabled captured fatal-error bits and `sw_ferr`.
- R4: `err_busy` rises in the cycle after an `accept` seen while the enabled reset-request OR is high. A request with no accept never raises it.
- R5: Once raised, `err_busy` stays high for as long as the enabled reset-request OR stays high.
- R6: When the request drops, `fe_reset` is high for exactly one cycle while `err_busy` is still high, and `err_busy` is low in the next cycle.
- R7: Each `accept` makes `busy_out` high for exactly 16 cycles, starting the cycle after it. A new accept restarts the count.
- R8: `test_busy` is set by `trigger` only while `test_en` is 1, is unaffected by a trigger otherwise, and is cleared by `test_clr`, which wins over a simultaneous trigger.
- R9: `busy_out` is the OR of `err_busy`, the enabled captured module busy bits, the internal accept window, `cal_busy`, `test_busy` and `sw_busy`.
- R10: While `local_mode` is 1, `busy_out` is 1.
- R11: After reset, with all inputs low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| local_mode | input | 1 | Local operation; forces busy |
| accept | input | 1 | Valid accept pulse |
| trigger | input | 1 | Trigger pulse for the test busy latch |
| cal_busy | input | 1 | Calibration busy |
| sw_busy | input | 1 | Software busy bit |
| sw_ferr | input | 1 | Software fatal-error bit |
| test_en | input | 1 | Enables setting of test busy |
| test_clr | input | 1 | Clears test busy |
| ret_busy | input | 5 | Busy returns, one per module |
| ret_rreq | input | 5 | Reset-request returns |
| ret_ferr | input | 5 | Fatal-error returns |
| keep_busy | input | 5 | Enable per busy return (1 = counts) |
| keep_rreq | input | 5 | Enable per reset-request return |
| keep_ferr | input | 5 | Enable per fatal-error return |
| busy_out | output | 1 | Combined busy to the trigger system |
| ferr_out | output | 1 | Combined fatal error |
| err_irq | output | 1 | Enabled reset-request OR, active high |
| fe_reset | output | 1 | One-cycle front-end reset |
| err_busy | output | 1 | Busy from the reset-request handshake |
| test_busy | output | 1 | Test busy latch |

## Verification
The handshake state machine is the hardest part to observe. A stuck or skipped state shows up at `fe_reset` and `err_busy`. It appears one or two cycles after the captured request clears, or in the cycle after an accept that meets a request. A wrong load or decrement of the window counter moves the falling edge of `busy_out` away from the seventeenth cycle after an accept, provided no other source is active. A wrong capture or gate of a return changes `busy_out`, `ferr_out` or `err_irq` one cycle after the input changes. A bench model checks all six outputs every cycle against random inputs. Directed sequences pin down the latency and the exact pulse edges.

// File: rtl/busy_agg_pkg.sv
package busy_agg_pkg;
  typedef enum logic [1:0] {
    ERR_IDLE  = 2'd0,
    ERR_HOLD  = 2'd1,
    ERR_PULSE = 2'd2
  } err_state_e;

  localparam int unsigned GROUPS = 3;
  localparam int unsigned G_BUSY = 0;
  localparam int unsigned G_RREQ = 1;
  localparam int unsigned G_FERR = 2;
endpackage

// File: rtl/ret_mask_or.sv
module ret_mask_or #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ret_in,
  input  logic [N-1:0] keep,
  output logic         any_hit
);
  logic [N-1:0] ret_q;

  function automatic logic masked_any(input logic [N-1:0] v, input logic [N-1:0] en);
    return |(v & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_q <= '0;
    else        ret_q <= ret_in;
  end

  assign any_hit = masked_any(ret_q, keep);

  // R1
  cap_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_in == '0) |=> (ret_q == '0));
endmodule

// File: rtl/err_reset_fsm.sv
module err_reset_fsm
  import busy_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rreq_any,
  input  logic accept,
  output logic err_busy,
  output logic fe_reset
);
  err_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ERR_IDLE:  if (rreq_any && accept) state_nx = ERR_HOLD;
      ERR_HOLD:  if (!rreq_any)          state_nx = ERR_PULSE;
      ERR_PULSE:                         state_nx = ERR_IDLE;
      default:                           state_nx = ERR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ERR_IDLE;
    else        state <= state_nx;
  end

  assign err_busy = (state != ERR_IDLE);
  assign fe_reset = (state == ERR_PULSE);

  // R4
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_busy) |-> $past(accept && rreq_any));
  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_busy && !fe_reset && rreq_any) |=> err_busy);
  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_reset |=> (!fe_reset && !err_busy));
endmodule

// File: rtl/int_busy_timer.sv
module int_busy_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] next_count(input logic acc, input logic [CW-1:0] c);
    if (acc)          return CW'(LEN);
    else if (c != '0) return c - CW'(1);
    else              return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(accept, cnt);
  end

  assign busy = (cnt != '0);

  // R7
  int_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cnt == CW'(LEN)));
  // R7
  int_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/busy_err_combiner.sv
module busy_err_combiner
  import busy_agg_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned WIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               local_mode,
  input  logic               accept,
  input  logic               trigger,
  input  logic               cal_busy,
  input  logic               sw_busy,
  input  logic               sw_ferr,
  input  logic               test_en,
  input  logic               test_clr,
  input  logic [NUM_MOD-1:0] ret_busy,
  input  logic [NUM_MOD-1:0] ret_rreq,
  input  logic [NUM_MOD-1:0] ret_ferr,
  input  logic [NUM_MOD-1:0] keep_busy,
  input  logic [NUM_MOD-1:0] keep_rreq,
  input  logic [NUM_MOD-1:0] keep_ferr,
  output logic               busy_out,
  output logic               ferr_out,
  output logic               err_irq,
  output logic               fe_reset,
  output logic               err_busy,
  output logic               test_busy
);
  logic [GROUPS-1:0][NUM_MOD-1:0] grp_in, grp_keep;
  logic [GROUPS-1:0]              grp_any;
  logic                           win_busy;

  assign grp_in[G_BUSY]   = ret_busy;
  assign grp_in[G_RREQ]   = ret_rreq;
  assign grp_in[G_FERR]   = ret_ferr;
  assign grp_keep[G_BUSY] = keep_busy;
  assign grp_keep[G_RREQ] = keep_rreq;
  assign grp_keep[G_FERR] = keep_ferr;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    ret_mask_or #(.N(NUM_MOD)) i_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .ret_in  (grp_in[g]),
      .keep    (grp_keep[g]),
      .any_hit (grp_any[g])
    );
  end

  err_reset_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rreq_any (grp_any[G_RREQ]),
    .accept   (accept),
    .err_busy (err_busy),
    .fe_reset (fe_reset)
  );

  int_busy_timer #(.LEN(WIN_LEN)) i_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .busy   (win_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   test_busy <= 1'b0;
    else if (test_clr)            test_busy <= 1'b0;
    else if (trigger && test_en)  test_busy <= 1'b1;
  end

  assign err_irq  = grp_any[G_RREQ];
  assign ferr_out = grp_any[G_FERR] | sw_ferr;
  assign busy_out = local_mode | err_busy | grp_any[G_BUSY] | win_busy
                  | cal_busy | test_busy | sw_busy;

  // R10
  local_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_mode |-> busy_out);
  // R3
  sw_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ferr |-> ferr_out);
  // R8
  test_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr |=> !test_busy);
  // R8
  test_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !test_clr) |=> (test_busy == $past(test_busy)));
  // R9
  win_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy |-> busy_out);
endmodule

// File: tb/test_busy_err_combiner.sv
module test_busy_err_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic local_mode = 0, accept = 0, trigger = 0, cal_busy = 0, sw_busy = 0, sw_ferr = 0;
  logic test_en = 0, test_clr = 0;
  logic [N-1:0] ret_busy = '0, ret_rreq = '0, ret_ferr = '0;
  logic [N-1:0] keep_busy = '0, keep_rreq = '0, keep_ferr = '0;
  logic busy_out, ferr_out, err_irq, fe_reset, err_busy, test_busy;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [N-1:0] m_busy_q = '0, m_rreq_q = '0, m_ferr_q = '0;
  int m_st = 0;       // 0 idle, 1 holding busy, 2 reset pulse
  int m_cnt = 0;
  logic m_tb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busy_err_combiner #(.NUM_MOD(N), .WIN_LEN(WIN)) i_busy_err_combiner (
    .clk(clk), .rst_n(rst_n), .local_mode(local_mode), .accept(accept), .trigger(trigger),
    .cal_busy(cal_busy), .sw_busy(sw_busy), .sw_ferr(sw_ferr), .test_en(test_en),
    .test_clr(test_clr), .ret_busy(ret_busy), .ret_rreq(ret_rreq), .ret_ferr(ret_ferr),
    .keep_busy(keep_busy), .keep_rreq(keep_rreq), .keep_ferr(keep_ferr),
    .busy_out(busy_out), .ferr_out(ferr_out), .err_irq(err_irq), .fe_reset(fe_reset),
    .err_busy(err_busy), .test_busy(test_busy)
  );

  function automatic logic gated(input logic [N-1:0] v, input logic [N-1:0] en);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) if (v[i] && en[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic exp_busy();
    return local_mode || (m_st != 0) || gated(m_busy_q, keep_busy) || (m_cnt > 0)
           || cal_busy || m_tb || sw_busy;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic rq = gated(m_rreq_q, keep_rreq);
    case (m_st)
      0: if (rq && accept) m_st = 1;
      1: if (!rq) m_st = 2;
      default: m_st = 0;
    endcase
    if (accept) m_cnt = WIN; else if (m_cnt > 0) m_cnt--;
    if (test_clr) m_tb = 0; else if (trigger && test_en) m_tb = 1;
    m_busy_q = ret_busy; m_rreq_q = ret_rreq; m_ferr_q = ret_ferr;
  endtask

  task automatic compare_all();
    chk("R9 busy_out", busy_out, exp_busy());
    chk("R3 ferr_out", ferr_out, gated(m_ferr_q, keep_ferr) || sw_ferr);
    chk("R2 err_irq", err_irq, gated(m_rreq_q, keep_rreq));
    chk("R6 fe_reset", fe_reset, m_st == 2);
    chk("R5 err_busy", err_busy, m_st != 0);
    chk("R8 test_busy", test_busy, m_tb);
  endtask

  // inputs set by caller at a negedge; advance one cycle and compare at next negedge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic clear_inputs();
    local_mode = 0; accept = 0; trigger = 0; cal_busy = 0; sw_busy = 0; sw_ferr = 0;
    test_en = 0; test_clr = 0; ret_busy = '0; ret_rreq = '0; ret_ferr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 busy_out", busy_out, 1'b0);
    chk("R11 ferr_out", ferr_out, 1'b0);
    chk("R11 err_irq", err_irq, 1'b0);
    chk("R11 fe_reset", fe_reset, 1'b0);
    chk("R11 err_busy", err_busy, 1'b0);
    chk("R11 test_busy", test_busy, 1'b0);

    // R10 local mode forces busy
    local_mode = 1; #1; chk("R10 local busy", busy_out, 1'b1);
    @(negedge clk); local_mode = 0; tick();

    // R1 enable gating and one-cycle capture latency
    keep_busy = 5'b00000; ret_busy = 5'b00100; tick();
    chk("R1 disabled busy ignored", busy_out, 1'b0);
    keep_busy = 5'b00100; #1;
    chk("R1 enabled after capture", busy_out, 1'b1);
    ret_busy = 5'b00000; #1;
    chk("R1 before edge still set", busy_out, 1'b1);
    tick(); chk("R1 cleared after edge", busy_out, 1'b0);
    keep_ferr = 5'b10000; ret_ferr = 5'b10000; tick();
    chk("R3 module 4 fatal", ferr_out, 1'b1);
    ret_ferr = '0; keep_ferr = '0; tick();

    // R4 request without accept raises nothing; R5 hold; R6 pulse
    keep_rreq = 5'b00010; ret_rreq = 5'b00010;
    for (int i = 0; i < 4; i++) tick();
    chk("R2 irq up", err_irq, 1'b1);
    chk("R4 no accept no busy", err_busy, 1'b0);
    accept = 1; tick(); accept = 0;
    chk("R4 busy after accept", err_busy, 1'b1);
    for (int i = 0; i < 20; i++) tick();
    chk("R5 still held", err_busy, 1'b1);
    chk("R5 no pulse yet", fe_reset, 1'b0);
    ret_rreq = '0; tick();
    chk("R6 busy while capture clears", err_busy, 1'b1);
    chk("R6 no pulse yet", fe_reset, 1'b0);
    tick();
    chk("R6 pulse", fe_reset, 1'b1);
    chk("R6 busy during pulse", err_busy, 1'b1);
    tick();
    chk("R6 pulse ends", fe_reset, 1'b0);
    chk("R6 busy released", err_busy, 1'b0);
    for (int i = 0; i < 20; i++) tick();

    // R7 window of exactly 16 cycles
    accept = 1; tick(); accept = 0;
    chk("R7 window cycle 1", busy_out, 1'b1);
    for (int i = 2; i <= WIN; i++) begin
      tick(); chk("R7 window high", busy_out, 1'b1);
    end
    tick(); chk("R7 window over", busy_out, 1'b0);
    accept = 1; tick(); accept = 0;
    for (int i = 0; i < 10; i++) tick();
    accept = 1; tick(); accept = 0;
    for (int i = 2; i <= WIN; i++) tick();
    chk("R7 restart extends", busy_out, 1'b1);
    tick(); chk("R7 restart ends", busy_out, 1'b0);

    // R8 test busy
    trigger = 1; tick(); trigger = 0;
    chk("R8 trigger ignored when disabled", test_busy, 1'b0);
    test_en = 1; trigger = 1; tick(); trigger = 0;
    chk("R8 set", test_busy, 1'b1);
    chk("R9 test busy drives busy", busy_out, 1'b1);
    test_en = 0; tick(); chk("R8 held", test_busy, 1'b1);
    test_en = 1; trigger = 1; test_clr = 1; tick();
    chk("R8 clear wins", test_busy, 1'b0);
    trigger = 0; test_clr = 0; test_en = 0; tick();

    // R9 other sources
    cal_busy = 1; tick(); chk("R9 cal busy", busy_out, 1'b1);
    cal_busy = 0; sw_busy = 1; tick(); chk("R9 sw busy", busy_out, 1'b1);
    sw_busy = 0; tick(); chk("R9 all quiet", busy_out, 1'b0);

    // random phase
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1234);
    end
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(31) == 0) keep_busy = N'($urandom);
      if ($urandom_range(31) == 0) keep_rreq = N'($urandom);
      if ($urandom_range(31) == 0) keep_ferr = N'($urandom);
      ret_busy = N'($urandom) & N'($urandom);
      ret_ferr = N'($urandom) & N'($urandom) & N'($urandom);
      if ($urandom_range(15) == 0) ret_rreq = N'($urandom);
      accept   = ($urandom_range(7) == 0);
      trigger  = ($urandom_range(7) == 0);
      test_en  = ($urandom_range(1) == 0);
      test_clr = ($urandom_range(15) == 0);
      cal_busy = ($urandom_range(15) == 0);
      sw_busy  = ($urandom_range(15) == 0);
      sw_ferr  = ($urandom_range(15) == 0);
      local_mode = ($urandom_range(31) == 0);
      tick();
    end
    clear_inputs();
    for (int i = 0; i < 25; i++) tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule